// File: doc/BRIEF.md
# Burst Write Bus Master

This block is the initiator side of a PCI-style shared parallel bus. It carries one write job at a time. A job is a start address and a word count, and the block moves that many 32-bit words from a local buffer into memory. To do this it requests the bus and waits for a grant. It then drives an address phase that carries the memory-write command and runs data phases whose pace is set by the target's ready signal. Each bus tenure carries at most `BURST` words. When words remain after a tenure, the block waits a fixed gap of idle clocks, requests the bus again, and resumes at the first word that has not yet been written.

The target can cut a tenure short in three ways. It can disconnect on a word that still moves. It can disconnect on a word that does not move. It can abort, in which case the job is abandoned with an error. If no target claims the cycle within `DEVTO` data clocks, the block gives up with an error (master abort).

An option input keeps the bus request asserted through the data phases until the next-to-last one. Parity over the address/data and command lines follows every driven phase by one clock.

Top module: `pci_burst_wr`

## Requirements
- R1: After reset, `bus_req`, `frame`, `irdy`, `ad_oe`, `par_oe`, `done` and `err` are all 0.
- R2: Each tenure begins with one address phase, in which `frame` is 1, `irdy` is 0, `ad_out` holds the byte address of the next unwritten word and `cbe_out` is 4'b0111 (memory write). Data phases drive `cbe_out` = 4'b0000.
- R3: A word is written only in a clock where `irdy`, `trdy` and `devsel` are all 1. Words are written in buffer order, word i at start address + 4*i, and `buf_idx` selects the word being driven. Target wait states (`trdy` low) move nothing.
- R4: A tenure carries at most `BURST` words. `frame` is 0 during the final data phase of a tenure while `irdy` stays 1, and `irdy` only falls after a clock in which `frame` was already 0.
- R5: With `ext_req`=1, `bus_req` stays 1 in every data phase except the last of the tenure, where it is 0. With `ext_req`=0, `bus_req` is 0 once the address phase has begun.
- R6: If `stop` comes with `devsel` and `trdy` while `frame` is 1, that word is still written. The next clock has `frame`=0 and `irdy`=1, and the clock after that has `irdy`=0.
- R7: If `stop` comes with `devsel` but without `trdy`, the current word is not written and is sent first in the next tenure.
- R8: When words remain after `irdy` falls at the end of a tenure, two clocks follow with no request, and `bus_req` rises in the third clock after the fall.
- R9: In the clock after any clock with `ad_oe`=1, `par_oe` is 1 and `par_out` equals the XOR of the previous clock's `ad_out` and `cbe_out` (even parity).
- R10: `stop` with `devsel`=0 in a data phase is a target abort. No further word is written, `err` rises, `done` pulses, and the bus is not requested again.
- R11: If `devsel` stays 0 for `DEVTO` data clocks after an address phase, the job ends with `err`=1 and a `done` pulse, and no word is written.
- R12: `done` is a one-clock pulse in the release clock of the job's final tenure, or in the clock after `start` for a count of 0. `err` is 0 for a job that completes, and it is cleared by `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a job (sampled while idle) |
| start_addr | input | 32 | Byte address of the first word |
| word_cnt | input | CW | Number of words to write |
| ext_req | input | 1 | Hold the request until the next-to-last data phase |
| done | output | 1 | Job finished pulse |
| err | output | 1 | Job ended by target or master abort |
| buf_idx | output | CW | Buffer index of the word being driven |
| buf_data | input | 32 | Buffer word at `buf_idx` (combinational read) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| frame | output | 1 | Cycle framing, active high |
| irdy | output | 1 | Initiator ready, active high |
| devsel | input | 1 | Target claims the cycle |
| trdy | input | 1 | Target ready |
| stop | input | 1 | Target requests termination |
| ad_out | output | 32 | Address/data lines |
| ad_oe | output | 1 | Drive enable for `ad_out` and `cbe_out` |
| cbe_out | output | 4 | Command / byte enables |
| par_out | output | 1 | Parity of the previous driven phase |
| par_oe | output | 1 | Drive enable for `par_out` |

## Verification
Results fall in fixed clocks:
- The address phase follows the granted request clock by one.
- A write lands in the same clock in which `irdy`, `trdy` and `devsel` are all high.
- Parity follows its phase by one clock.
- After a disconnect, `frame` drops one clock later and `irdy` two clocks later.
- The renewed request rises three clocks after `irdy` falls.

The bench target answers at the falling edge. The scoreboard monitor samples one nanosecond later, so it sees exactly the values the design samples at the next rising edge. Every timing check is made against a cycle count kept by the monitor itself.

// File: rtl/pci_burst_wr.sv
module pci_burst_wr #(
  parameter int CW    = 8,
  parameter int BURST = 4,
  parameter int DEVTO = 5,
  parameter int GAP   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          ext_req,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] buf_idx,
  input  logic [31:0]   buf_data,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          frame,
  output logic          irdy,
  input  logic          devsel,
  input  logic          trdy,
  input  logic          stop,
  output logic [31:0]   ad_out,
  output logic          ad_oe,
  output logic [3:0]    cbe_out,
  output logic          par_out,
  output logic          par_oe
);
  localparam int TW  = $clog2(BURST + 1);
  localparam int DTW = $clog2(DEVTO + 1);
  localparam int GW  = $clog2(GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_DROP, S_REL, S_GAP} st_t;

  st_t           st;
  logic [31:0]   addr;
  logic [CW-1:0] rem, idx;
  logic [TW-1:0] tleft;
  logic [DTW-1:0] dcnt;
  logic [GW-1:0] gcnt;
  logic          dseen, abort_q, err_q, par_q, par_oe_q;

  wire last     = (tleft == TW'(1));
  wire data_ph  = (st == S_DATA);
  wire end_tail = last;

  assign frame   = (st == S_ADDR) || (data_ph && !last);
  assign irdy    = data_ph || (st == S_DROP);
  assign ad_oe   = (st == S_ADDR) || irdy;
  assign bus_req = (st == S_REQ) || (ext_req && frame);
  assign ad_out  = (st == S_ADDR) ? addr : buf_data;
  assign cbe_out = (st == S_ADDR) ? 4'b0111 : 4'b0000;
  assign done    = (st == S_REL) && (abort_q || rem == '0);
  assign err     = err_q;
  assign buf_idx = idx;
  assign par_out = par_q;
  assign par_oe  = par_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; rem <= '0; idx <= '0; tleft <= '0;
      dcnt <= '0; gcnt <= '0; dseen <= 1'b0; abort_q <= 1'b0;
      err_q <= 1'b0; par_q <= 1'b0; par_oe_q <= 1'b0;
    end else begin
      par_q    <= ^{ad_out, cbe_out};
      par_oe_q <= ad_oe;
      case (st)
        S_IDLE: if (start) begin
          addr <= start_addr; rem <= word_cnt; idx <= '0;
          err_q <= 1'b0; abort_q <= 1'b0;
          st <= (word_cnt == '0) ? S_REL : S_REQ;
        end
        S_REQ: if (bus_gnt) begin
          tleft <= (rem > CW'(BURST)) ? TW'(BURST) : TW'(rem);
          dcnt <= '0; dseen <= 1'b0;
          st <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (dcnt != DTW'(DEVTO)) dcnt <= dcnt + DTW'(1);
          if (devsel) dseen <= 1'b1;
          if (stop && !devsel) begin
            abort_q <= 1'b1; err_q <= 1'b1;
            st <= end_tail ? S_REL : S_DROP;
          end else if (devsel && trdy) begin
            idx <= idx + CW'(1); rem <= rem - CW'(1);
            addr <= addr + 32'd4; tleft <= tleft - TW'(1);
            if (last) st <= S_REL;
            else if (stop) st <= S_DROP;
          end else if (devsel && stop) begin
            st <= end_tail ? S_REL : S_DROP;
          end else if (!devsel && !dseen && dcnt == DTW'(DEVTO - 1)) begin
            abort_q <= 1'b1; err_q <= 1'b1;
            st <= end_tail ? S_REL : S_DROP;
          end
        end
        S_DROP: st <= S_REL;
        S_REL: begin
          gcnt <= '0;
          st <= (abort_q || rem == '0) ? S_IDLE : S_GAP;
        end
        S_GAP: begin
          gcnt <= gcnt + GW'(1);
          if (gcnt == GW'(GAP - 1)) st <= S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_burst_wr_chk.sv
module pci_burst_wr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_req,
  input logic       bus_req,
  input logic       frame,
  input logic       irdy,
  input logic       devsel,
  input logic       stop,
  input logic [3:0] cbe_out,
  input logic       ad_oe,
  input logic       done
);
  a_r2_addr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> (cbe_out == 4'b0111 && ad_oe && !irdy));

  a_r4_frame_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irdy) |-> !$past(frame));

  a_r5_no_ext_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_req && irdy) |-> !bus_req);

  a_r6_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && irdy && devsel && stop) |=> (!frame && irdy));

  a_r10_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && irdy && !devsel && stop) |=> (!frame && irdy));

  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!frame && !irdy && !bus_req));
endmodule

bind pci_burst_wr pci_burst_wr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .bus_req(bus_req),
  .frame(frame), .irdy(irdy), .devsel(devsel), .stop(stop),
  .cbe_out(cbe_out), .ad_oe(ad_oe), .done(done)
);

// File: tb/pci_burst_wr_tb.sv
`timescale 1ns/100ps
module pci_burst_wr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ext_req = 1'b0;
  logic [31:0] start_addr = '0;
  logic [7:0]  word_cnt = '0;
  logic done, err, bus_req, frame, irdy, ad_oe, par_out, par_oe;
  logic [7:0]  buf_idx;
  logic [31:0] buf_data, ad_out;
  logic [3:0]  cbe_out;
  logic t_gnt = 0, t_devsel = 0, t_trdy = 0, t_stop = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] fdata(input int i);
    return 32'h9E37_0000 ^ (i * 32'h0101_0101);
  endfunction
  assign buf_data = fdata(int'(buf_idx));

  pci_burst_wr u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_cnt(word_cnt), .ext_req(ext_req), .done(done), .err(err),
    .buf_idx(buf_idx), .buf_data(buf_data), .bus_req(bus_req), .bus_gnt(t_gnt),
    .frame(frame), .irdy(irdy), .devsel(t_devsel), .trdy(t_trdy), .stop(t_stop),
    .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out), .par_out(par_out), .par_oe(par_oe));

  int nvec = 0, nerr = 0;
  task automatic chk(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%h expected=%h", rq, act, exp); end
  endtask

  // target model configuration
  int cf_devdly = 1, cf_wait0 = 0, cf_stop_at = 0;
  bit cf_stop_data = 0, cf_stop_arm = 0, cf_abort = 0, cf_nodev = 0;
  int t_cyc = 0, t_beat = 0;
  bit t_act = 0, t_stopped = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      t_gnt = 0; t_devsel = 0; t_trdy = 0; t_stop = 0; t_act = 0;
    end else begin
      t_gnt = bus_req;
      if (frame && !irdy) begin
        t_act = 1; t_cyc = 0; t_beat = 0; t_stopped = 0;
        t_devsel = 0; t_trdy = 0; t_stop = 0;
      end else if (t_act && irdy) begin
        t_cyc++;
        if (t_stopped) t_trdy = 0;
        else if (cf_nodev || t_cyc < cf_devdly) begin
          t_devsel = 0; t_trdy = 0; t_stop = 0;
        end else if (cf_abort) begin
          t_devsel = 0; t_trdy = 0; t_stop = 1; t_stopped = 1;
        end else begin
          t_devsel = 1;
          t_trdy = (t_beat > 0) || (t_cyc >= cf_devdly + cf_wait0);
          if (cf_stop_arm && t_beat == cf_stop_at && (t_trdy || !cf_stop_data)) begin
            if (!cf_stop_data) t_trdy = 0;
            t_stop = 1; t_stopped = 1; cf_stop_arm = 0;
          end
          if (t_trdy) t_beat++;
        end
      end else begin
        t_act = 0; t_devsel = 0; t_trdy = 0; t_stop = 0;
      end
    end
  end

  typedef struct packed {
    logic        is_beat;
    logic        last;
    logic        req;
    logic [31:0] a;
    logic [31:0] d;
  } item_t;
  item_t exq[$];

  // monitor
  int cyc = 0, stop_t = -100, rel_t = -100;
  bit rel_v = 0, p_frame = 0, p_irdy = 0, p_oe = 0, p_req = 0;
  logic [31:0] p_ad = '0;
  logic [3:0]  p_cbe = '0;
  item_t it;

  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      cyc++;
      if (p_oe) chk("R9 parity", par_oe && par_out == ^{p_ad, p_cbe},
                    {31'd0, par_out}, {31'd0, ^{p_ad, p_cbe}});
      if (frame && !irdy && ad_oe) begin
        if (exq.size() == 0) chk("R2 unexpected address phase", 0, ad_out, 0);
        else begin
          it = exq.pop_front();
          chk("R2 address phase kind", !it.is_beat, 32'd0, {31'd0, it.is_beat});
          chk("R2 address", ad_out == it.a, ad_out, it.a);
          chk("R2 command 0111", cbe_out == 4'b0111, {28'd0, cbe_out}, 32'h7);
        end
      end
      if (irdy && t_devsel && t_trdy) begin
        if (exq.size() == 0) chk("R3 unexpected word", 0, ad_out, 0);
        else begin
          it = exq.pop_front();
          chk("R3 word kind", it.is_beat, 32'd0, 32'd1);
          chk("R3 word data", ad_out == it.d, ad_out, it.d);
          chk("R3 byte enables", cbe_out == 4'b0000, {28'd0, cbe_out}, 32'h0);
          chk("R4 frame on final phase", frame == !it.last, {31'd0, frame}, {31'd0, !it.last});
          chk("R5 request in data phase", bus_req == it.req, {31'd0, bus_req}, {31'd0, it.req});
        end
      end
      if (frame && irdy && t_stop) stop_t = cyc;
      if (p_irdy && !irdy) begin
        chk("R4 frame low before irdy falls", !p_frame, {31'd0, p_frame}, 32'd0);
        if (stop_t > rel_t) chk("R6 irdy falls two clocks after stop", cyc == stop_t + 2, cyc, stop_t + 2);
        rel_t = cyc; rel_v = 1;
      end
      if (!p_req && bus_req && rel_v) begin
        chk("R8 request gap", cyc == rel_t + 3, cyc, rel_t + 3);
        rel_v = 0;
      end
      if (done) rel_v = 0;
      p_frame = frame; p_irdy = irdy; p_oe = ad_oe; p_req = bus_req;
      p_ad = ad_out; p_cbe = cbe_out;
    end
  end

  task automatic run(input string rq, input int n, input logic [31:0] a0, input bit ext,
                     input int devdly, input int wait0, input bit stop_en, input int stop_at,
                     input bit stop_data, input bit abrt, input bit nodev);
    int w = 0, k, m, any_req = 0;
    bit first = 1;
    item_t x;
    while (w < n) begin
      m = (n - w > 4) ? 4 : n - w;
      x = '0; x.a = a0 + 32'(4 * w); exq.push_back(x);
      if (abrt || nodev) break;
      k = m;
      if (stop_en && first && stop_at < m) k = stop_data ? stop_at + 1 : stop_at;
      for (int i = 0; i < k; i++) begin
        x.is_beat = 1; x.last = (i == m - 1); x.req = ext && (i != m - 1);
        x.a = a0 + 32'(4 * (w + i)); x.d = fdata(w + i);
        exq.push_back(x);
      end
      w += k; first = 0;
    end
    @(negedge clk);
    cf_devdly = devdly; cf_wait0 = wait0; cf_stop_at = stop_at; cf_stop_data = stop_data;
    cf_stop_arm = stop_en; cf_abort = abrt; cf_nodev = nodev;
    ext_req = ext; start_addr = a0; word_cnt = 8'(n); start = 1;
    @(negedge clk); start = 0;
    #1;
    while (!done) begin @(negedge clk); #1; end
    chk({rq, " done pulse"}, done, {31'd0, done}, 32'd1);
    @(negedge clk); #1;
    chk("R12 done is one clock", !done, {31'd0, done}, 32'd0);
    chk({rq, " error flag"}, err == (abrt || nodev), {31'd0, err}, {31'd0, abrt || nodev});
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1; if (bus_req) any_req++; end
    chk({rq, " no request after job"}, any_req == 0, any_req, 0);
    chk({rq, " all expected phases seen"}, exq.size() == 0, exq.size(), 0);
    exq.delete();
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset req", !bus_req, {31'd0, bus_req}, 0);
    chk("R1 reset frame/irdy", !frame && !irdy, {30'd0, frame, irdy}, 0);
    chk("R1 reset drivers", !ad_oe && !par_oe, {30'd0, ad_oe, par_oe}, 0);
    chk("R1 reset done/err", !done && !err, {30'd0, done, err}, 0);
    #11 rst_n = 1;
    run("R12 two tenures ext", 6, 32'h0000_1000, 1, 1, 0, 0, 0, 0, 0, 0);
    run("R3 wait states", 5, 32'h0000_2040, 0, 2, 3, 0, 0, 0, 0, 0);
    run("R6 disconnect with data", 7, 32'h0001_0000, 1, 1, 0, 1, 1, 1, 0, 0);
    run("R7 disconnect without data", 6, 32'h0002_0100, 0, 1, 0, 1, 2, 0, 0, 0);
    run("R10 target abort", 4, 32'h0003_0000, 1, 1, 0, 0, 0, 0, 1, 0);
    run("R11 master abort", 3, 32'h0004_0000, 0, 1, 0, 0, 0, 0, 0, 1);
    run("R12 zero count", 0, 32'h0005_0000, 0, 1, 0, 0, 0, 0, 0, 0);
    run("R5 single word", 1, 32'h0006_0008, 1, 1, 0, 0, 0, 0, 0, 0);
    run("R12 long job", 11, 32'h0007_0000, 1, 1, 1, 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule